// File: doc/BRIEF.md
# Register-Mapped Signed 64-bit Divider

This block is a small coprocessor for signed integer division. Software loads a numerator and a denominator into word registers, then writes a 16-bit control register. That write picks one of four operand-width modes and starts a division. The block returns a 64-bit quotient and a 64-bit remainder, each readable as a pair of 32-bit words. While the unit works, a hardware-owned busy bit stays set and both result registers read zero. A zero denominator does not stall or trap the unit. It produces a defined result and raises a status flag.

Inside, a restoring divider works on operand magnitudes and resolves two quotient bits per clock. The signs are applied afterwards. The busy period is padded to a fixed latency for each mode, so software polling sees the same timing for every operand value.

The bus is a simple synchronous port with separate read and write strobes, an access size and a byte offset. The byte offsets are as follows:
- Control register: 0x00.
- Numerator: 0x10 (low word) and 0x14 (high word).
- Denominator: 0x18 (low word) and 0x1C (high word).
- Quotient: 0x20 (low word) and 0x24 (high word).
- Remainder: 0x28 (low word) and 0x2C (high word).

Top module: `sdiv_regblock`

## Requirements
- R1: After reset, every register reads zero: control, operands and results. `bus_rdata` is zero.
- R2: A 16-bit read at offset 0x00 returns a control word. The mode is in bits 1:0, the divide-by-zero flag in bit 14 and busy in bit 15, and all other bits are zero. All read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is sampled.
- R3: A 16-bit write at offset 0x00 loads the mode from `bus_wdata[1:0]` and starts a division. From the next clock busy reads 1 and divide-by-zero reads 0, whatever values the write carried in bits 15 and 14.
- R4: From the start until completion, the quotient words at 0x20/0x24 and the remainder words at 0x28/0x2C read zero.
- R5: Busy stays set for exactly LAT_SHORT clocks (34 by default) in mode 0 and LAT_LONG clocks (68) in modes 1 to 3. The results and the flag are updated on the same edge at which busy clears.
- R6: Mode 0 divides the low numerator word by the low denominator word, each sign-extended to 64 bits. The high words are ignored.
- R7: Mode 1 divides the full 64-bit numerator by the low denominator word sign-extended to 64 bits.
- R8: Modes 2 and 3 both divide the 64-bit numerator by the 64-bit denominator.
- R9: For a non-zero denominator, the quotient is truncated toward zero and the remainder carries the numerator's sign.
- R10: For a zero effective denominator, the quotient is +1 if the numerator is negative and -1 otherwise. The remainder equals the numerator and the divide-by-zero flag (bit 14) is set.
- R11: A start issued while busy abandons the running division. It restarts with the operands and mode current at that write, and the latency is counted from the new start.
- R12: Accesses to offsets 0x00 to 0x03 that are not a 16-bit access at 0x00 are ignored. Such a write changes neither mode nor results and starts nothing, and such a read returns 0.
- R13: The operand words read back the last values written by 32-bit writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Take the control write edge as E. A read sampled at E+1 must already show busy set and divide-by-zero clear, and the result words must read zero. A read sampled at E+LAT must still show busy, and one sampled at E+LAT+1 must show it clear, together with the final flag and results. The bench counts clock edges from E and places every read strobe so that the sampling edge lands on these exact cycles. The restart case re-bases E on the second write, which shows that the first operation's end time no longer matters.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
  typedef enum logic [1:0] {
    MD_S32     = 2'd0,
    MD_S64_32  = 2'd1,
    MD_S64_64A = 2'd2,
    MD_S64_64B = 2'd3
  } mode_e;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
endpackage

// File: rtl/sdiv_opregs.sv
`timescale 1ns/1ps
module sdiv_opregs #(
  parameter int DW = 32,
  parameter int NW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [$clog2(NW)-1:0] widx,
  input  logic [DW-1:0]         wdata,
  input  logic [$clog2(NW)-1:0] ridx,
  output logic [DW-1:0]         rword,
  output logic [2*DW-1:0]       num,
  output logic [2*DW-1:0]       den
);
  logic [DW-1:0] words [NW];

  generate
    for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)                         words[g] <= '0;
        else if (we && widx == g[$clog2(NW)-1:0]) words[g] <= wdata;
      end
    end
  endgenerate

  assign rword = words[ridx];
  assign num   = {words[1], words[0]};
  assign den   = {words[3], words[2]};
endmodule

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
module sdiv_core import sdiv_pkg::*; #(
  parameter int W   = 64,
  parameter int BPC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  mode_e        mode,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         dz
);
  localparam int HALF = W / 2;
  localparam int SW   = $clog2(W / BPC + 1);

  logic [W-1:0]  n_eff, d_eff, mag_n, mag_d;
  logic          short_op;
  logic [W-1:0]  sh_q, dvs, nq;
  logic [W:0]    sh_r, nr;
  logic          neg_n, neg_d, zero_d, run;
  logic [SW-1:0] steps;

  always_comb begin
    short_op = (mode == MD_S32);
    n_eff = short_op ? {{HALF{num[HALF-1]}}, num[HALF-1:0]} : num;
    d_eff = (mode == MD_S32 || mode == MD_S64_32) ?
            {{HALF{den[HALF-1]}}, den[HALF-1:0]} : den;
    mag_n = n_eff[W-1] ? -n_eff : n_eff;
    mag_d = d_eff[W-1] ? -d_eff : d_eff;
  end

  // BPC restoring steps per clock
  always_comb begin
    logic [W:0] t;
    nq = sh_q;
    nr = sh_r;
    for (int i = 0; i < BPC; i++) begin
      t  = {nr[W-1:0], nq[W-1]};
      nq = {nq[W-2:0], 1'b0};
      if (t >= {1'b0, dvs}) begin
        t     = t - {1'b0, dvs};
        nq[0] = 1'b1;
      end
      nr = t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0; sh_r <= '0; dvs <= '0;
      neg_n <= 1'b0; neg_d <= 1'b0; zero_d <= 1'b0;
      steps <= '0; run <= 1'b0; done <= 1'b0;
    end else if (start) begin
      sh_r   <= '0;
      sh_q   <= short_op ? {mag_n[HALF-1:0], {HALF{1'b0}}} : mag_n;
      dvs    <= mag_d;
      neg_n  <= n_eff[W-1];
      neg_d  <= d_eff[W-1];
      zero_d <= (d_eff == '0);
      steps  <= short_op ? SW'(HALF / BPC) : SW'(W / BPC);
      run    <= 1'b1;
      done   <= 1'b0;
    end else if (run) begin
      sh_q  <= nq;
      sh_r  <= nr;
      steps <= steps - 1'b1;
      if (steps == SW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // With a zero divisor every step subtracts nothing, so the partial
  // remainder ends up holding the numerator magnitude.
  always_comb begin
    if (zero_d) quo = neg_n ? W'(1) : '1;
    else        quo = (neg_n ^ neg_d) ? -sh_q : sh_q;
    rem = neg_n ? -sh_r[W-1:0] : sh_r[W-1:0];
    dz  = zero_d;
  end

  // R10
  dz_quo_chk: assert property (@(posedge clk) disable iff (rst)
    (done && dz) |-> (quo == W'(1) || quo == '1));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !run);
endmodule

// File: rtl/sdiv_regblock.sv
`timescale 1ns/1ps
module sdiv_regblock import sdiv_pkg::*; #(
  parameter int ADDR_W    = 6,
  parameter int LAT_SHORT = 34,
  parameter int LAT_LONG  = 68,
  parameter int BPC       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int DW = 32;
  localparam int W  = 2 * DW;
  localparam int CW = $clog2(LAT_LONG + 1);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] widx;
  logic          ctrl_zone, ctrl_ok, word_ok, start, op_we;
  mode_e         mode_q, new_mode;
  logic          busy_q, dz_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  q_q, r_q, num, den, core_q, core_r;
  logic          core_done, core_dz;
  logic [DW-1:0] op_word, rd_mux;

  always_comb begin
    widx      = bus_addr[ADDR_W-1:2];
    ctrl_zone = (widx == '0);
    ctrl_ok   = ctrl_zone && bus_addr[1:0] == 2'b00 && bus_size == SZ_H;
    word_ok   = bus_size == SZ_W && bus_addr[1:0] == 2'b00;
    start     = bus_wr && ctrl_ok;
    op_we     = bus_wr && word_ok && widx >= IW'(4) && widx <= IW'(7);
    new_mode  = mode_e'(bus_wdata[1:0]);
  end

  sdiv_opregs #(.DW(DW), .NW(4)) u_ops (
    .clk(clk), .rst(rst), .we(op_we), .widx(widx[1:0]), .wdata(bus_wdata),
    .ridx(widx[1:0]), .rword(op_word), .num(num), .den(den)
  );

  sdiv_core #(.W(W), .BPC(BPC)) u_core (
    .clk(clk), .rst(rst), .start(start), .mode(new_mode), .num(num), .den(den),
    .done(core_done), .quo(core_q), .rem(core_r), .dz(core_dz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_S32; busy_q <= 1'b0; dz_q <= 1'b0;
      cnt <= '0; q_q <= '0; r_q <= '0;
    end else if (start) begin
      mode_q <= new_mode;
      busy_q <= 1'b1;
      dz_q   <= 1'b0;
      q_q    <= '0;
      r_q    <= '0;
      cnt    <= (new_mode == MD_S32) ? CW'(LAT_SHORT - 1) : CW'(LAT_LONG - 1);
    end else if (busy_q) begin
      if (cnt == '0) begin
        busy_q <= 1'b0;
        q_q    <= core_q;
        r_q    <= core_r;
        dz_q   <= core_dz;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_ok) rd_mux = {16'h0, busy_q, dz_q, 12'h0, mode_q};
    else if (word_ok) begin
      case (widx)
        IW'(4), IW'(5), IW'(6), IW'(7): rd_mux = op_word;
        IW'(8):  rd_mux = q_q[DW-1:0];
        IW'(9):  rd_mux = q_q[W-1:DW];
        IW'(10): rd_mux = r_q[DW-1:0];
        IW'(11): rd_mux = r_q[W-1:DW];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && !dz_q));
  // R4
  busy_zero_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (q_q == '0 && r_q == '0));
  // R5
  core_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt == '0 && !start) |-> core_done);
  // R10
  dz_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dz_q |-> !busy_q);
  // R12
  ignore_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_zone && !ctrl_ok && !busy_q) |=> (!busy_q && $stable(mode_q)));
endmodule

// File: tb/tb_sdiv_regblock.sv
`timescale 1ns/1ps
module tb_sdiv_regblock;
  localparam int LS = 34;
  localparam int LL = 68;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  sdiv_regblock dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [1:0] s, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [1:0] s, int tgt, output logic [31:0] v);
    while (cyc < tgt - 1) @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(negedge clk);
    v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic void model(int md, logic [63:0] n, logic [63:0] d,
                                output logic [63:0] q, output logic [63:0] r,
                                output logic z);
    logic signed [63:0] ne, de;
    ne = (md == 0) ? {{32{n[31]}}, n[31:0]} : n;
    de = (md <= 1) ? {{32{d[31]}}, d[31:0]} : d;
    if (de == 0) begin
      z = 1'b1; q = (ne < 0) ? 64'd1 : '1; r = ne;
    end else begin
      z = 1'b0; q = ne / de; r = ne % de;
    end
  endfunction

  task automatic load_ops(logic [63:0] n, logic [63:0] d);
    wr(6'h10, 2'd2, n[31:0]); wr(6'h14, 2'd2, n[63:32]);
    wr(6'h18, 2'd2, d[31:0]); wr(6'h1C, 2'd2, d[63:32]);
  endtask

  task automatic check_done(string tag, int md, int e, logic [63:0] n, logic [63:0] d);
    logic [31:0] v, lo, hi;
    logic [63:0] q, r;
    logic z;
    int lat;
    model(md, n, d, q, r, z);
    lat = (md == 0) ? LS : LL;
    rd(6'h00, 2'd1, e + lat, v);
    chk("R5 busy at last cycle", v, 64'h8000 | md);
    rd(6'h00, 2'd1, e + lat + 1, v);
    chk("R2/R5 ctrl after done", v, {z, 14'h0} | md);
    rd(6'h20, 2'd2, 0, lo); rd(6'h24, 2'd2, 0, hi);
    chk({tag, " quotient"}, {hi, lo}, q);
    rd(6'h28, 2'd2, 0, lo); rd(6'h2C, 2'd2, 0, hi);
    chk({tag, " remainder"}, {hi, lo}, r);
  endtask

  task automatic run_div(string tag, int md, logic [63:0] n, logic [63:0] d);
    logic [31:0] v;
    int e;
    load_ops(n, d);
    wr(6'h00, 2'd1, 32'h0000_C000 | md);  // bits 15:14 set by software: ignored
    e = cyc;
    rd(6'h00, 2'd1, e + 1, v);
    chk("R3 busy set, div0 cleared", v, 64'h8000 | md);
    rd(6'h20, 2'd2, e + 2, v);
    chk("R4 quotient zero while busy", v, 0);
    rd(6'h2C, 2'd2, e + 3, v);
    chk("R4 remainder zero while busy", v, 0);
    check_done(tag, md, e, n, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata after reset", bus_rdata, 0);
    rd(6'h00, 2'd1, 0, v); chk("R1 ctrl", v, 0);
    rd(6'h20, 2'd2, 0, v); chk("R1 quotient", v, 0);
    rd(6'h1C, 2'd2, 0, v); chk("R1 operand", v, 0);
  endtask

  task automatic t_restart();
    int e2;
    load_ops(64'd1000, 64'd10);
    wr(6'h00, 2'd1, 32'h2);
    repeat (5) @(negedge clk);
    wr(6'h18, 2'd2, 32'hFFFF_FFF9);
    wr(6'h00, 2'd1, 32'h0);
    e2 = cyc;
    check_done("R11 restart", 0, e2, 64'd1000, 64'h0000_000A_FFFF_FFF9);
  endtask

  task automatic t_access();
    logic [31:0] v;
    wr(6'h00, 2'd0, 32'h03);
    rd(6'h00, 2'd1, 0, v); chk("R12 byte ctrl write ignored", v, 0);
    wr(6'h00, 2'd2, 32'h8003);
    rd(6'h00, 2'd1, 0, v); chk("R12 word ctrl write ignored", v, 0);
    rd(6'h20, 2'd2, 0, v); chk("R12 no start, quotient kept", v, 64'hFFFF_FF72);
    rd(6'h00, 2'd0, 0, v); chk("R12 byte ctrl read", v, 0);
    rd(6'h01, 2'd0, 0, v); chk("R12 byte ctrl read +1", v, 0);
    rd(6'h00, 2'd2, 0, v); chk("R12 word ctrl read", v, 0);
  endtask

  task automatic t_opread();
    logic [31:0] v;
    wr(6'h14, 2'd2, 32'hA5A5_1234);
    rd(6'h14, 2'd2, 0, v); chk("R13 operand readback", v, 64'hA5A5_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_div("R6 R9 ++", 0, 64'h1234_5678_0000_0064, 64'hDEAD_0000_0000_0007);
    run_div("R6 R9 -+", 0, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_0000_0007);
    run_div("R6 R9 +-", 0, 64'h0000_0000_0000_0064, 64'h0000_0000_FFFF_FFF9);
    run_div("R6 R9 --", 0, 64'h0000_0000_FFFF_FF9C, 64'h0000_0000_FFFF_FFF9);
    run_div("R7", 1, 64'h0123_4567_89AB_CDEF, 64'h7777_0000_FFFF_FFFD);
    run_div("R8 mode2", 2, 64'hF000_0000_0000_0001, 64'h0000_0001_0000_0003);
    run_div("R8 mode3", 3, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000);
    run_div("R10 neg", 0, 64'h0000_0000_FFFF_FFFB, 64'h0000_0001_0000_0000);
    run_div("R10 pos", 2, 64'd9, 64'd0);
    run_div("R3 after div0", 1, 64'd77, 64'd5);
    t_restart();
    t_access();
    t_opread();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule